// File: doc/BRIEF.md
# Deep-Pipeline Hazard Stall Interlock

This block is the hazard interlock for an eleven-stage DSP pipeline. The stages are four fetch stages, decode, address generation, four memory stages and two execute stages, and compute overlaps the last memory stage. Each cycle the instruction waiting in decode is presented as an abstract descriptor. The descriptor gives up to two destination operands, two source operands, a set of behaviour flags and up to two data-memory accesses with their bank numbers. The block keeps its own record of the last two instructions it let through. It compares the waiting instruction against them and picks a stall length. It then holds decode, and everything behind it, for exactly that many cycles. In each held cycle it inserts a bubble into the address-generation stage.

Decode offers an instruction with `dec_valid`, and the interlock accepts it with `dec_ready`. An instruction is accepted in the cycle where both are high. While `dec_ready` is low, the producer must keep `dec_valid` high and keep every descriptor field constant. `stall` is the inverse of `dec_ready`. `stall_cnt` gives the number of held cycles still to come, counting the current one. One cycle after an acceptance, `ag_valid` goes high to show that the address-generation stage holds a real instruction. In every other cycle it is low, which marks a bubble.

Top module: `pipe_hazard_interlock`

## Requirements
- R1: After reset, `stall` is 0, `stall_cnt` is 0, `ag_valid` is 0 and `dec_ready` is 1. The record of older instructions is empty, so the first instruction accepted stalls 0 cycles. Operand class codes are: 0 none, 1 compute data register, 2 address-generator register, 3 other register.
- R2: Suppose the previous instruction loads an address-generator register from memory (`d_ld_mem`=1 with a class-2 destination). If the next instruction reads that same register as a source, the stall is 4 cycles. If it reads a different register number, the stall is 0.
- R3: The address-register load of R2 costs 1 extra cycle if it is conditional (`d_cond`) and the instruction before it set flags (`d_setflg`). It also costs 1 extra cycle if the load uses sign extension (`d_sext`). Both extras add up to a maximum of 6 cycles.
- R4: Writing an address-generator register without a memory load (an immediate, `d_ld_mem`=0) and then reading it costs 0 stall cycles.
- R5: A conditional store (`d_st_mem`=1, `d_cond`=1) followed directly by any load (`d_ld_mem`=1) costs 1 cycle. An unconditional store costs 0. One intervening instruction also makes the stall 0.
- R6: An instruction whose two data accesses are both enabled and name the same bank stalls 1 cycle. Accesses to different banks stall 0.
- R7: A multiplier instruction (`d_mul`) stalls when both of its data-register sources match, in either order, the two distinct data-register destinations of one earlier instruction. The stall is 2 cycles if that instruction is the one just before, and 1 cycle if it is two instructions back.
- R8: A floating-point instruction (`d_fp`) that reads a data register written by the floating-point instruction just before it stalls 1 cycle. A reader that is not floating-point stalls 0.
- R9: Suppose an instruction's first destination is outside the processing element (class 2 or 3). If it reads a data register written by a floating-point or multiplier instruction just before it, it stalls 1 cycle.
- R10: When several hazards apply to the same instruction, the stall is the largest single penalty, not the sum.
- R11: A stall of P cycles keeps `stall` high and `dec_ready` low for exactly P consecutive cycles, with `stall_cnt` stepping P, P-1, ..., 1. The instruction is accepted in the following cycle.
- R12: `ag_valid` is 1 in the cycle after an acceptance. It is 0 after a held cycle or a cycle with no offer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode offers an instruction |
| dec_ready | output | 1 | Interlock accepts the offered instruction |
| d_dst0_cls | input | 2 | Class of first destination |
| d_dst0_num | input | 4 | Number of first destination |
| d_dst1_cls | input | 2 | Class of second destination |
| d_dst1_num | input | 4 | Number of second destination |
| d_srca_cls | input | 2 | Class of first source |
| d_srca_num | input | 4 | Number of first source |
| d_srcb_cls | input | 2 | Class of second source |
| d_srcb_num | input | 4 | Number of second source |
| d_ld_mem | input | 1 | Destination is loaded from memory |
| d_st_mem | input | 1 | Instruction stores to memory |
| d_cond | input | 1 | Instruction is conditional |
| d_setflg | input | 1 | Instruction sets condition flags |
| d_sext | input | 1 | Load uses sign extension |
| d_fp | input | 1 | Floating-point compute |
| d_mul | input | 1 | Multiplier operation |
| d_acc0_en | input | 1 | First data access present |
| d_acc0_bank | input | 2 | Bank of first data access |
| d_acc1_en | input | 1 | Second data access present |
| d_acc1_bank | input | 2 | Bank of second data access |
| stall | output | 1 | Decode and earlier stages held this cycle |
| stall_cnt | output | 3 | Held cycles remaining, counting this one |
| ag_valid | output | 1 | Address-generation stage holds a real instruction |

## Verification
The assertions assume that decode never withdraws or changes an offer while it is held. Under that rule, the countdown of `stall_cnt` and the release after the last held cycle are guaranteed, and a held cycle is always followed by a bubble. The bench keeps within this rule by itself. It raises `dec_valid` with a fixed descriptor and keeps both unchanged until it sees `dec_ready` high at a sample point. Only then does it move to the next instruction or to an idle cycle. Operand numbers in the random phase are drawn from a small range, so that register matches and bank clashes occur often.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
  localparam int NUM_W  = 4;
  localparam int BANK_W = 2;
  localparam int HIST   = 2;

  typedef enum logic [1:0] {
    RC_NONE = 2'd0,
    RC_DATA = 2'd1,
    RC_ADDR = 2'd2,
    RC_MISC = 2'd3
  } rclass_e;

  typedef struct packed {
    rclass_e            c;
    logic [NUM_W-1:0]   n;
  } opnd_t;

  typedef struct packed {
    opnd_t              dst0;
    opnd_t              dst1;
    opnd_t              srca;
    opnd_t              srcb;
    logic               ld_mem;
    logic               st_mem;
    logic               cond;
    logic               setflg;
    logic               sext;
    logic               fp;
    logic               mul;
    logic               acc0_en;
    logic [BANK_W-1:0]  acc0_bank;
    logic               acc1_en;
    logic [BANK_W-1:0]  acc1_bank;
  } instr_t;

  function automatic logic same_reg(opnd_t s, opnd_t d, rclass_e k);
    return (s.c == k) && (d.c == k) && (s.n == d.n);
  endfunction

  function automatic logic reads_dst(instr_t cur, instr_t old, rclass_e k);
    return same_reg(cur.srca, old.dst0, k) || same_reg(cur.srca, old.dst1, k) ||
           same_reg(cur.srcb, old.dst0, k) || same_reg(cur.srcb, old.dst1, k);
  endfunction
endpackage

// File: rtl/ilk_history.sv
module ilk_history
  import ilk_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   push,
  input  instr_t din,
  output instr_t ent [HIST],
  output logic   vld [HIST]
);
  genvar g;
  generate
    for (g = 0; g < HIST; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ent[g] <= '0;
          vld[g] <= 1'b0;
        end else if (push) begin
          if (g == 0) begin
            ent[g] <= din;
            vld[g] <= 1'b1;
          end else begin
            ent[g] <= ent[g-1];
            vld[g] <= vld[g-1];
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/ilk_rules.sv
module ilk_rules
  import ilk_pkg::*;
#(
  parameter int CNT_W     = 3,
  parameter int LD_PEN    = 4,
  parameter int COND_ADD  = 1,
  parameter int SEXT_ADD  = 1,
  parameter int CSTLD_PEN = 1,
  parameter int BANK_PEN  = 1,
  parameter int DUAL1_PEN = 2,
  parameter int DUAL2_PEN = 1,
  parameter int FPFP_PEN  = 1,
  parameter int XPE_PEN   = 1
) (
  input  instr_t           cur,
  input  instr_t           p1,
  input  logic             p1_v,
  input  instr_t           p2,
  input  logic             p2_v,
  output logic [CNT_W-1:0] pen
);
  localparam int NRULE = 6;

  logic [CNT_W-1:0] cand [NRULE];

  function automatic logic dual_src(instr_t c, instr_t o);
    logic pair_ok, ops_ok;
    pair_ok = (o.dst0.c == RC_DATA) && (o.dst1.c == RC_DATA) && (o.dst0.n != o.dst1.n);
    ops_ok  = (c.srca.c == RC_DATA) && (c.srcb.c == RC_DATA);
    return c.mul && pair_ok && ops_ok &&
           (((c.srca.n == o.dst0.n) && (c.srcb.n == o.dst1.n)) ||
            ((c.srca.n == o.dst1.n) && (c.srcb.n == o.dst0.n)));
  endfunction

  logic addr_use, data_use, outside;
  int   ld_cost;

  always_comb begin
    addr_use = p1_v && reads_dst(cur, p1, RC_ADDR);
    data_use = p1_v && reads_dst(cur, p1, RC_DATA);
    outside  = (cur.dst0.c == RC_ADDR) || (cur.dst0.c == RC_MISC);
    ld_cost  = LD_PEN;
    if (p1.cond && p2_v && p2.setflg) ld_cost = ld_cost + COND_ADD;
    if (p1.sext) ld_cost = ld_cost + SEXT_ADD;

    // R2 R3 R4: memory load of an address register, then use
    cand[0] = (addr_use && p1.ld_mem) ? CNT_W'(ld_cost) : '0;
    // R5: conditional store directly before any load
    cand[1] = (p1_v && p1.st_mem && p1.cond && cur.ld_mem) ? CNT_W'(CSTLD_PEN) : '0;
    // R6: two accesses to one bank
    cand[2] = (cur.acc0_en && cur.acc1_en && (cur.acc0_bank == cur.acc1_bank))
              ? CNT_W'(BANK_PEN) : '0;
    // R7: both multiplier operands forwarded
    if (p1_v && dual_src(cur, p1))      cand[3] = CNT_W'(DUAL1_PEN);
    else if (p2_v && dual_src(cur, p2)) cand[3] = CNT_W'(DUAL2_PEN);
    else                                cand[3] = '0;
    // R8: floating-point to floating-point
    cand[4] = (data_use && p1.fp && cur.fp) ? CNT_W'(FPFP_PEN) : '0;
    // R9: result leaves the processing element
    cand[5] = (data_use && (p1.fp || p1.mul) && outside) ? CNT_W'(XPE_PEN) : '0;
  end

  // R10: largest penalty wins
  always_comb begin
    pen = '0;
    for (int i = 0; i < NRULE; i++) begin
      if (cand[i] > pen) pen = cand[i];
    end
  end
endmodule

// File: rtl/ilk_stall_ctl.sv
module ilk_stall_ctl #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid,
  input  logic [CNT_W-1:0] pen,
  output logic             stall,
  output logic [CNT_W-1:0] stall_left,
  output logic             issue,
  output logic             ag_valid
);
  logic [CNT_W-1:0] cnt_q;
  logic             served_q;
  logic             busy;
  logic [CNT_W-1:0] pen_eff;

  always_comb begin
    busy       = (cnt_q != '0);
    pen_eff    = served_q ? '0 : pen;
    stall_left = busy ? cnt_q : (dec_valid ? pen_eff : '0);
    stall      = (stall_left != '0);
    issue      = dec_valid && !stall;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      served_q <= 1'b0;
      ag_valid <= 1'b0;
    end else begin
      ag_valid <= issue;
      if (busy) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) served_q <= 1'b1;
      end else if (stall) begin
        cnt_q <= pen_eff - 1'b1;
        if (pen_eff == CNT_W'(1)) served_q <= 1'b1;
      end
      if (issue) served_q <= 1'b0;
    end
  end

  p_cnt_down_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && stall_left > CNT_W'(1)) |=> (stall && stall_left == $past(stall_left) - 1'b1));

  p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && stall_left == CNT_W'(1)) |=> !stall);

  p_bubble_r12: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !ag_valid);

  p_issue_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !stall) |=> ag_valid);
endmodule

// File: rtl/pipe_hazard_interlock.sv
module pipe_hazard_interlock
  import ilk_pkg::*;
#(
  parameter int LD_PEN    = 4,
  parameter int COND_ADD  = 1,
  parameter int SEXT_ADD  = 1,
  parameter int CSTLD_PEN = 1,
  parameter int BANK_PEN  = 1,
  parameter int DUAL1_PEN = 2,
  parameter int DUAL2_PEN = 1,
  parameter int FPFP_PEN  = 1,
  parameter int XPE_PEN   = 1,
  localparam int MAX_PEN  = LD_PEN + COND_ADD + SEXT_ADD,
  localparam int CNT_W    = $clog2(MAX_PEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_valid,
  output logic              dec_ready,
  input  logic [1:0]        d_dst0_cls,
  input  logic [NUM_W-1:0]  d_dst0_num,
  input  logic [1:0]        d_dst1_cls,
  input  logic [NUM_W-1:0]  d_dst1_num,
  input  logic [1:0]        d_srca_cls,
  input  logic [NUM_W-1:0]  d_srca_num,
  input  logic [1:0]        d_srcb_cls,
  input  logic [NUM_W-1:0]  d_srcb_num,
  input  logic              d_ld_mem,
  input  logic              d_st_mem,
  input  logic              d_cond,
  input  logic              d_setflg,
  input  logic              d_sext,
  input  logic              d_fp,
  input  logic              d_mul,
  input  logic              d_acc0_en,
  input  logic [BANK_W-1:0] d_acc0_bank,
  input  logic              d_acc1_en,
  input  logic [BANK_W-1:0] d_acc1_bank,
  output logic              stall,
  output logic [CNT_W-1:0]  stall_cnt,
  output logic              ag_valid
);
  instr_t           cur;
  instr_t           hist_e [HIST];
  logic             hist_v [HIST];
  logic [CNT_W-1:0] pen;
  logic             issue;

  always_comb begin
    cur.dst0      = '{c: rclass_e'(d_dst0_cls), n: d_dst0_num};
    cur.dst1      = '{c: rclass_e'(d_dst1_cls), n: d_dst1_num};
    cur.srca      = '{c: rclass_e'(d_srca_cls), n: d_srca_num};
    cur.srcb      = '{c: rclass_e'(d_srcb_cls), n: d_srcb_num};
    cur.ld_mem    = d_ld_mem;
    cur.st_mem    = d_st_mem;
    cur.cond      = d_cond;
    cur.setflg    = d_setflg;
    cur.sext      = d_sext;
    cur.fp        = d_fp;
    cur.mul       = d_mul;
    cur.acc0_en   = d_acc0_en;
    cur.acc0_bank = d_acc0_bank;
    cur.acc1_en   = d_acc1_en;
    cur.acc1_bank = d_acc1_bank;
  end

  ilk_history u_hist (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (issue),
    .din   (cur),
    .ent   (hist_e),
    .vld   (hist_v)
  );

  ilk_rules #(
    .CNT_W(CNT_W), .LD_PEN(LD_PEN), .COND_ADD(COND_ADD), .SEXT_ADD(SEXT_ADD),
    .CSTLD_PEN(CSTLD_PEN), .BANK_PEN(BANK_PEN), .DUAL1_PEN(DUAL1_PEN),
    .DUAL2_PEN(DUAL2_PEN), .FPFP_PEN(FPFP_PEN), .XPE_PEN(XPE_PEN)
  ) u_rules (
    .cur  (cur),
    .p1   (hist_e[0]),
    .p1_v (hist_v[0]),
    .p2   (hist_e[1]),
    .p2_v (hist_v[1]),
    .pen  (pen)
  );

  ilk_stall_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_valid  (dec_valid),
    .pen        (pen),
    .stall      (stall),
    .stall_left (stall_cnt),
    .issue      (issue),
    .ag_valid   (ag_valid)
  );

  assign dec_ready = !stall;

  p_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (stall_cnt <= CNT_W'(MAX_PEN)));

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_valid && !$past(stall)) |-> !stall);
endmodule

// File: tb/sim_pipe_hazard_interlock.sv
`timescale 1ns/1ps
module sim_pipe_hazard_interlock;
  import ilk_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  instr_t d;
  logic dec_valid = 1'b0;
  logic dec_ready, stall, ag_valid;
  logic [2:0] stall_cnt;

  pipe_hazard_interlock u0 (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .d_dst0_cls(d.dst0.c), .d_dst0_num(d.dst0.n),
    .d_dst1_cls(d.dst1.c), .d_dst1_num(d.dst1.n),
    .d_srca_cls(d.srca.c), .d_srca_num(d.srca.n),
    .d_srcb_cls(d.srcb.c), .d_srcb_num(d.srcb.n),
    .d_ld_mem(d.ld_mem), .d_st_mem(d.st_mem), .d_cond(d.cond),
    .d_setflg(d.setflg), .d_sext(d.sext), .d_fp(d.fp), .d_mul(d.mul),
    .d_acc0_en(d.acc0_en), .d_acc0_bank(d.acc0_bank),
    .d_acc1_en(d.acc1_en), .d_acc1_bank(d.acc1_bank),
    .stall(stall), .stall_cnt(stall_cnt), .ag_valid(ag_valid)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference history, newest first
  instr_t ref_q[$];
  bit     exp_ag = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit rd(instr_t c, instr_t o, rclass_e k);
    opnd_t s[2];
    opnd_t t[2];
    s[0] = c.srca; s[1] = c.srcb; t[0] = o.dst0; t[1] = o.dst1;
    foreach (s[i]) foreach (t[j])
      if (s[i].c == k && t[j].c == k && s[i].n == t[j].n) return 1;
    return 0;
  endfunction

  function automatic bit pair(instr_t c, instr_t o);
    if (!c.mul) return 0;
    if (c.srca.c != RC_DATA || c.srcb.c != RC_DATA) return 0;
    if (o.dst0.c != RC_DATA || o.dst1.c != RC_DATA || o.dst0.n == o.dst1.n) return 0;
    return (c.srca.n == o.dst0.n && c.srcb.n == o.dst1.n) ||
           (c.srca.n == o.dst1.n && c.srcb.n == o.dst0.n);
  endfunction

  function automatic int model_pen(instr_t c);
    int costs[$];
    int best = 0;
    bit h1 = ref_q.size() > 0;
    bit h2 = ref_q.size() > 1;
    if (h1 && ref_q[0].ld_mem && rd(c, ref_q[0], RC_ADDR))
      costs.push_back(4 + ((ref_q[0].cond && h2 && ref_q[1].setflg) ? 1 : 0)
                        + (ref_q[0].sext ? 1 : 0));
    if (h1 && ref_q[0].st_mem && ref_q[0].cond && c.ld_mem) costs.push_back(1);
    if (c.acc0_en && c.acc1_en && c.acc0_bank == c.acc1_bank) costs.push_back(1);
    if (h1 && pair(c, ref_q[0])) costs.push_back(2);
    else if (h2 && pair(c, ref_q[1])) costs.push_back(1);
    if (h1 && ref_q[0].fp && c.fp && rd(c, ref_q[0], RC_DATA)) costs.push_back(1);
    if (h1 && (ref_q[0].fp || ref_q[0].mul) && rd(c, ref_q[0], RC_DATA) &&
        (c.dst0.c == RC_ADDR || c.dst0.c == RC_MISC)) costs.push_back(1);
    foreach (costs[i]) if (costs[i] > best) best = costs[i];
    return best;
  endfunction

  // offer one instruction, compare each cycle, check total hold against exp
  task automatic send(instr_t x, int exp, string tag);
    int p;
    int n = 0;
    p = model_pen(x);
    @(negedge clk);
    d = x; dec_valid = 1'b1;
    forever begin
      #1;
      chk(stall == (n < p), "R11 stall", stall, n < p);
      chk(stall_cnt == ((n < p) ? p - n : 0), "R11 stall_cnt", stall_cnt, (n < p) ? p - n : 0);
      chk(dec_ready == !stall, "R11 dec_ready", dec_ready, !stall);
      chk(ag_valid == exp_ag, "R12 ag_valid", ag_valid, exp_ag);
      exp_ag = !stall;
      if (!stall) break;
      n++;
      @(negedge clk);
    end
    if (exp >= 0) chk(n == exp, tag, n, exp);
    ref_q.push_front(x);
    if (ref_q.size() > 2) void'(ref_q.pop_back());
  endtask

  task automatic idle();
    @(negedge clk);
    dec_valid = 1'b0; d = '0;
    #1;
    chk(stall == 0 && stall_cnt == 0, "R1 idle no stall", stall_cnt, 0);
    chk(ag_valid == exp_ag, "R12 ag_valid idle", ag_valid, exp_ag);
    exp_ag = 0;
  endtask

  function automatic instr_t nop();
    return '0;
  endfunction
  function automatic opnd_t op(rclass_e k, int n);
    opnd_t o; o.c = k; o.n = NUM_W'(n); return o;
  endfunction

  initial begin
    #3000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    instr_t a, b, c;
    d = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(stall == 0, "R1 reset stall", stall, 0);
    chk(stall_cnt == 0, "R1 reset stall_cnt", stall_cnt, 0);
    chk(ag_valid == 0, "R1 reset ag_valid", ag_valid, 0);
    chk(dec_ready == 1, "R1 reset ready", dec_ready, 1);

    a = nop(); a.srca = op(RC_ADDR, 2);
    send(a, 0, "R1 empty history");

    // R2
    a = nop(); a.dst0 = op(RC_ADDR, 4); a.ld_mem = 1; a.acc0_en = 1;
    b = nop(); b.srca = op(RC_ADDR, 4);
    send(a, -1, ""); send(b, 4, "R2 load-use");
    b.srca = op(RC_ADDR, 5);
    send(a, -1, ""); send(b, 0, "R2 other reg");

    // R3
    c = nop(); c.dst0 = op(RC_DATA, 0); c.setflg = 1;
    a = nop(); a.dst0 = op(RC_ADDR, 1); a.ld_mem = 1; a.cond = 1;
    b = nop(); b.srca = op(RC_ADDR, 1);
    send(c, -1, ""); send(a, -1, ""); send(b, 5, "R3 cond load");
    a.cond = 0; a.sext = 1;
    send(nop(), -1, ""); send(a, -1, ""); send(b, 5, "R3 sext load");
    a.cond = 1;
    send(c, -1, ""); send(a, -1, ""); send(b, 6, "R3 cond+sext");

    // R4
    a = nop(); a.dst0 = op(RC_ADDR, 3);
    b = nop(); b.srcb = op(RC_ADDR, 3);
    send(a, -1, ""); send(b, 0, "R4 immediate");

    // R5
    a = nop(); a.st_mem = 1; a.cond = 1; a.acc0_en = 1;
    b = nop(); b.ld_mem = 1; b.dst0 = op(RC_DATA, 1); b.acc0_en = 1;
    send(a, -1, ""); send(b, 1, "R5 cond store-load");
    a.cond = 0;
    send(a, -1, ""); send(b, 0, "R5 uncond store");
    a.cond = 1;
    send(a, -1, ""); send(nop(), -1, ""); send(b, 0, "R5 separated");

    // R6
    a = nop(); a.acc0_en = 1; a.acc1_en = 1; a.acc0_bank = 1; a.acc1_bank = 1;
    send(a, 1, "R6 same bank");
    a.acc1_bank = 2;
    send(a, 0, "R6 other bank");

    // R7
    a = nop(); a.dst0 = op(RC_DATA, 4); a.dst1 = op(RC_DATA, 12);
    b = nop(); b.mul = 1; b.srca = op(RC_DATA, 4); b.srcb = op(RC_DATA, 12);
    b.dst0 = op(RC_DATA, 14);
    send(a, -1, ""); send(b, 2, "R7 dual N-1");
    send(a, -1, ""); send(nop(), -1, ""); send(b, 1, "R7 dual N-2");
    b.srca = op(RC_DATA, 12); b.srcb = op(RC_DATA, 4);
    send(a, -1, ""); send(b, 2, "R7 swapped");

    // R8
    a = nop(); a.fp = 1; a.dst0 = op(RC_DATA, 1);
    b = nop(); b.fp = 1; b.srca = op(RC_DATA, 1); b.dst0 = op(RC_DATA, 2);
    send(a, -1, ""); send(b, 1, "R8 fp-fp");
    b.fp = 0;
    send(a, -1, ""); send(b, 0, "R8 non-fp reader");

    // R9
    b = nop(); b.dst0 = op(RC_MISC, 1); b.srca = op(RC_DATA, 1);
    send(a, -1, ""); send(b, 1, "R9 fp to misc");
    a = nop(); a.mul = 1; a.dst0 = op(RC_DATA, 2);
    b = nop(); b.dst0 = op(RC_ADDR, 0); b.srca = op(RC_DATA, 2);
    send(a, -1, ""); send(b, 1, "R9 mul to addr");

    // R10
    a = nop(); a.dst0 = op(RC_ADDR, 4); a.ld_mem = 1;
    b = nop(); b.srca = op(RC_ADDR, 4); b.acc0_en = 1; b.acc1_en = 1;
    send(a, -1, ""); send(b, 4, "R10 load+bank max");
    a = nop(); a.fp = 1; a.dst0 = op(RC_DATA, 4); a.dst1 = op(RC_DATA, 12);
    b = nop(); b.fp = 1; b.mul = 1; b.srca = op(RC_DATA, 4); b.srcb = op(RC_DATA, 12);
    send(a, -1, ""); send(b, 2, "R10 dual+fp max");

    // R12 bubble after idle
    idle(); idle();
    send(nop(), 0, "R12 after idle");

    // mixed traffic against the reference model
    for (int k = 0; k < 400; k++) begin
      instr_t r;
      r = '0;
      r.dst0 = op(rclass_e'($urandom_range(0, 3)), $urandom_range(0, 2));
      r.dst1 = op(rclass_e'($urandom_range(0, 1)), $urandom_range(0, 2));
      r.srca = op(rclass_e'($urandom_range(0, 3)), $urandom_range(0, 2));
      r.srcb = op(rclass_e'($urandom_range(0, 2)), $urandom_range(0, 2));
      r.ld_mem = 1'($urandom_range(0, 1)); r.st_mem = 1'($urandom_range(0, 1));
      r.cond = 1'($urandom_range(0, 1));   r.setflg = 1'($urandom_range(0, 1));
      r.sext = 1'($urandom_range(0, 1));   r.fp = 1'($urandom_range(0, 1));
      r.mul = 1'($urandom_range(0, 1));
      r.acc0_en = 1'($urandom_range(0, 1)); r.acc0_bank = 2'($urandom_range(0, 3));
      r.acc1_en = 1'($urandom_range(0, 1)); r.acc1_bank = 2'($urandom_range(0, 3));
      send(r, -1, "");
      if ($urandom_range(0, 7) == 0) idle();
    end
    idle();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule